// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is the shift and rotate execution unit of a 16-bit datapath that can also operate on 8-bit operands. Each request carries an operand, a shift count, a byte/word size select, a 3-bit operation code and the incoming carry flag. The block returns the shifted or rotated result, the new carry flag and an overflow flag. The zero, sign and parity flags are not produced here.

The carry flag takes part in the data path. For the two rotate-through-carry operations it acts as an extra bit above the operand, which gives a 9-bit or 17-bit rotation. For every operation with a nonzero count it ends up holding the last bit that left the operand. The operation is computed as a chain of single-bit steps, one for each possible count value.

Requests enter through a valid/ready stream and results leave through a second valid/ready stream. A single output register sits between the two streams. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The block raises `in_ready` whenever its output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new request is taken.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation codes 4 and 6 are both shift left and behave identically. Vacated low bits fill with 0, and the carry gets the last bit moved out of the operand's top bit.
- R2: Operation code 5 is logical shift right. Vacated high bits fill with 0, and the carry gets the last bit moved out of bit 0.
- R3: Operation code 7 is arithmetic shift right. Vacated high bits fill with the original top bit of the operand (bit 15, or bit 7 in byte mode), and the carry gets the last bit moved out of bit 0.
- R4: Operation code 0 is rotate left. The bit leaving the top enters both bit 0 and the carry.
- R5: Operation code 1 is rotate right. The bit leaving bit 0 enters both the top bit and the carry.
- R6: Operation code 2 is rotate left through carry. The old carry enters bit 0 and the bit leaving the top enters the carry, forming a rotation over 17 bits (9 in byte mode).
- R7: Operation code 3 is rotate right through carry. The old carry enters the top bit and the bit leaving bit 0 enters the carry, forming a rotation over 17 bits (9 in byte mode).
- R8: Only the low 5 bits of the 8-bit count are used. A masked count of 0 returns the operand unchanged, passes the incoming carry through, and clears overflow.
- R9: With `in_byte` high, only bits 7:0 are operated on, bit 7 acts as the top bit, and result bits 15:8 equal operand bits 15:8.
- R10: Overflow is 0 unless the masked count is 1. For a count of 1, overflow is defined per operation. Codes 0, 2, 4 and 6 give the new top bit XOR the new carry. Code 5 gives the original top bit. Code 7 gives 0. Codes 1 and 3 give the XOR of the two highest result bits.
- R11: A request transfers on an edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` on the next cycle. `in_ready` is low only while a held result is not being taken. A result is held unchanged until an edge where `out_ready` is high.
- R12: While `rst_n` is low, and right after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_data | input | 16 | Operand |
| in_count | input | 8 | Shift count; low 5 bits used |
| in_byte | input | 1 | 1 selects 8-bit operation on bits 7:0 |
| in_op | input | 3 | Operation code (see R1 to R7) |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Result |
| out_carry | output | 1 | New carry flag |
| out_ovf | output | 1 | Overflow flag |

## Verification
The hold assertions assume that the consumer follows the stream rules: it may drop `out_ready` at any time, and it takes a result only on an edge. The stimulus drives every input on the falling edge, so the assertions always see settled values. It keeps `in_valid` high until the request is taken, and it runs phases both with and without back-pressure. The combinational checks assume that the operation code and the count are known values on every cycle. The bench therefore keeps all request fields driven at all times, including when `in_valid` is low.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } srt_op_e;

  function automatic logic is_leftward(srt_op_e op);
    return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL) || (op == OP_SAL);
  endfunction
endpackage

// File: rtl/srt_lane.sv
module srt_lane
  import srt_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [LW-1:0] d_i,
  input  logic          c_i,
  input  srt_op_e       op_i,
  output logic [LW-1:0] d_o,
  output logic          c_o
);
  always_comb begin
    d_o = d_i;
    c_o = c_i;
    unique case (op_i)
      OP_ROL: begin d_o = {d_i[LW-2:0], d_i[LW-1]}; c_o = d_i[LW-1]; end
      OP_ROR: begin d_o = {d_i[0], d_i[LW-1:1]};    c_o = d_i[0];    end
      OP_RCL: begin d_o = {d_i[LW-2:0], c_i};       c_o = d_i[LW-1]; end
      OP_RCR: begin d_o = {c_i, d_i[LW-1:1]};       c_o = d_i[0];    end
      OP_SHL,
      OP_SAL: begin d_o = {d_i[LW-2:0], 1'b0};      c_o = d_i[LW-1]; end
      OP_SHR: begin d_o = {1'b0, d_i[LW-1:1]};      c_o = d_i[0];    end
      OP_SAR: begin d_o = {d_i[LW-1], d_i[LW-1:1]}; c_o = d_i[0];    end
      default: begin d_o = d_i; c_o = c_i; end
    endcase
  end
endmodule

// File: rtl/srt_step.sv
module srt_step
  import srt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              c_i,
  input  logic              en_i,
  input  logic              byte_i,
  input  srt_op_e           op_i,
  output logic [DATA_W-1:0] d_o,
  output logic              c_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] wide_d;
  logic              wide_c;
  logic [HALF_W-1:0] half_d;
  logic              half_c;

  srt_lane #(.LW(DATA_W)) u_wide (
    .d_i(d_i), .c_i(c_i), .op_i(op_i), .d_o(wide_d), .c_o(wide_c)
  );

  srt_lane #(.LW(HALF_W)) u_half (
    .d_i(d_i[HALF_W-1:0]), .c_i(c_i), .op_i(op_i), .d_o(half_d), .c_o(half_c)
  );

  always_comb begin
    if (!en_i) begin
      d_o = d_i;
      c_o = c_i;
    end else if (byte_i) begin
      d_o = {d_i[DATA_W-1:HALF_W], half_d};
      c_o = half_c;
    end else begin
      d_o = wide_d;
      c_o = wide_c;
    end
  end
endmodule

// File: rtl/srt_core.sv
module srt_core
  import srt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              byte_i,
  input  srt_op_e           op_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int STEPS  = (1 << MASK_W) - 1;

  logic [MASK_W-1:0] cnt_m;
  logic [DATA_W-1:0] chain_d [STEPS+1];
  logic              chain_c [STEPS+1];

  assign cnt_m      = cnt_i[MASK_W-1:0];
  assign chain_d[0] = opnd_i;
  assign chain_c[0] = cin_i;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    srt_step #(.DATA_W(DATA_W)) u_step (
      .d_i   (chain_d[i]),
      .c_i   (chain_c[i]),
      .en_i  (cnt_m > MASK_W'(i)),
      .byte_i(byte_i),
      .op_i  (op_i),
      .d_o   (chain_d[i+1]),
      .c_o   (chain_c[i+1])
    );
  end

  assign res_o  = chain_d[STEPS];
  assign cout_o = chain_c[STEPS];

  logic msb_in, msb_out, msb_next;
  assign msb_in   = byte_i ? opnd_i[HALF_W-1] : opnd_i[DATA_W-1];
  assign msb_out  = byte_i ? res_o[HALF_W-1]  : res_o[DATA_W-1];
  assign msb_next = byte_i ? res_o[HALF_W-2]  : res_o[DATA_W-2];

  always_comb begin
    ovf_o = 1'b0;
    if (cnt_m == MASK_W'(1)) begin
      if (is_leftward(op_i))                        ovf_o = msb_out ^ cout_o;
      else if (op_i == OP_SHR)                      ovf_o = msb_in;
      else if (op_i == OP_ROR || op_i == OP_RCR)    ovf_o = msb_out ^ msb_next;
      else                                          ovf_o = 1'b0;
    end
  end

  always_comb begin
    // R8
    if (cnt_m == '0) cnt_zero_chk: assert (res_o == opnd_i && cout_o == cin_i && !ovf_o);
    // R9
    if (byte_i) byte_pass_chk: assert (res_o[DATA_W-1:HALF_W] == opnd_i[DATA_W-1:HALF_W]);
    // R3
    if (op_i == OP_SAR) sar_sign_chk: assert (msb_out == msb_in);
  end
endmodule

// File: rtl/srt_outreg.sv
module srt_outreg #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_pay,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_pay
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_pay   <= in_pay;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pay));
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R11
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_byte,
  input  logic [2:0]        in_op,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_carry,
  output logic              out_ovf
);
  localparam int PW = DATA_W + 2;

  logic [DATA_W-1:0] res;
  logic              cout, ovf;
  logic [PW-1:0]     held;

  srt_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_core (
    .opnd_i(in_data),
    .cnt_i (in_count),
    .byte_i(in_byte),
    .op_i  (srt_op_e'(in_op)),
    .cin_i (in_carry),
    .res_o (res),
    .cout_o(cout),
    .ovf_o (ovf)
  );

  srt_outreg #(.PW(PW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pay   ({res, cout, ovf}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_pay  (held)
  );

  assign out_data  = held[PW-1:2];
  assign out_carry = held[1];
  assign out_ovf   = held[0];
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_data = 0;
  logic [7:0]  in_count = 0;
  logic        in_byte = 0;
  logic [2:0]  in_op = 0;
  logic        in_carry = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [15:0] out_data;
  logic        out_carry;
  logic        out_ovf;

  int tests = 0;
  int fails = 0;
  bit bp_on = 0;
  int cyc = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_count(in_count), .in_byte(in_byte), .in_op(in_op),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_carry(out_carry), .out_ovf(out_ovf)
  );

  function automatic logic [17:0] model(logic [15:0] d, logic [7:0] n, bit b, logic [2:0] op, bit ci);
    int W = b ? 8 : 16;
    int c = n & 31;
    logic [31:0] mask = (32'd1 << W) - 1;
    logic [31:0] v = b ? {24'b0, d[7:0]} : {16'b0, d};
    logic [31:0] r = 0, rv = 0, t;
    logic [47:0] x;
    logic signed [47:0] xs;
    logic [15:0] s16;
    logic cf = ci, ov = 0;
    int m, N;
    if (c == 0) return {d, ci, 1'b0};
    case (op)
      3'd4, 3'd6: begin x = {16'b0, v} << c; r = x[31:0] & mask; cf = x[W]; end
      3'd5: begin x = {v[15:0], 32'b0} >> c; r = {16'b0, x[47:32]}; cf = x[31]; end
      3'd7: begin
        s16 = b ? {{8{v[7]}}, v[7:0]} : v[15:0];
        xs = $signed({s16, 32'b0}) >>> c; r = {16'b0, xs[47:32]} & mask; cf = xs[31];
      end
      3'd0: begin m = c % W; r = ((v << m) | (v >> (W - m))) & mask; cf = r[0]; end
      3'd1: begin m = c % W; r = ((v >> m) | (v << (W - m))) & mask; cf = r[W-1]; end
      default: begin
        N = W + 1; m = c % N; t = v | (32'(ci) << W);
        if (op == 3'd2) rv = ((t << m) | (t >> (N - m))) & ((32'd1 << N) - 1);
        else            rv = ((t >> m) | (t << (N - m))) & ((32'd1 << N) - 1);
        r = rv & mask; cf = rv[W];
      end
    endcase
    if (c == 1) begin
      case (op)
        3'd0, 3'd2, 3'd4, 3'd6: ov = r[W-1] ^ cf;
        3'd5: ov = v[W-1];
        3'd7: ov = 1'b0;
        default: ov = r[W-1] ^ r[W-2];
      endcase
    end
    if (b) return {d[15:8], r[7:0], cf, ov};
    return {r[15:0], cf, ov};
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd5: return "R2";
      3'd7: return "R3";
      default: return "R1";
    endcase
  endfunction

  // Assumes the caller is at a falling edge.
  task automatic send(logic [15:0] d, logic [7:0] n, bit b, logic [2:0] op, bit ci, string tag);
    in_valid = 1; in_data = d; in_count = n; in_byte = b; in_op = op; in_carry = ci;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(d, n, b, op, ci));
    tag_q.push_back(tag == "" ? op_tag(op) : tag);
    @(negedge clk);
    in_valid = 0;
  endtask

  // Back-pressure generator
  initial forever begin
    @(negedge clk);
    cyc++;
    out_ready = !bp_on || (cyc % 3 != 0);
  end

  // Scoreboard monitor
  bit          was_stalled = 0;
  logic [17:0] stalled_val;
  initial forever begin
    @(negedge clk); #2;
    if (rst_n) begin
      if (was_stalled) begin
        tests++;
        if (!out_valid || {out_data, out_carry, out_ovf} != stalled_val) begin
          fails++;
          $display("FAIL R11 hold: got v=%0b %h exp v=1 %h", out_valid, {out_data, out_carry, out_ovf}, stalled_val);
        end
      end
      was_stalled = out_valid && !out_ready;
      stalled_val = {out_data, out_carry, out_ovf};
      if (out_valid && out_ready) begin
        logic [17:0] e;
        string t;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected result: got %h exp none", {out_data, out_carry, out_ovf});
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if ({out_data, out_carry, out_ovf} != e) begin
            fails++;
            $display("FAIL %s: got data=%h c=%0b v=%0b exp data=%h c=%0b v=%0b",
                     t, out_data, out_carry, out_ovf, e[17:2], e[1], e[0]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++; $display("FAIL R12 in reset: got v=%0b r=%0b exp v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1;
    @(negedge clk); #1;
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++; $display("FAIL R12 after reset: got v=%0b r=%0b exp v=0 r=1", out_valid, in_ready);
    end
    @(negedge clk);

    // R1 / R10 shift left, both codes
    send(16'h8001, 8'd1, 0, 3'd4, 0, "R1");
    send(16'h4000, 8'd1, 0, 3'd6, 0, "R10");
    send(16'h1234, 8'd16, 0, 3'd4, 0, "R1");
    send(16'h1235, 8'd16, 0, 3'd6, 0, "R1");
    // R2 / R3
    send(16'h8001, 8'd1, 0, 3'd5, 0, "R10");
    send(16'h8001, 8'd20, 0, 3'd5, 1, "R2");
    send(16'h8001, 8'd1, 0, 3'd7, 0, "R10");
    send(16'h8000, 8'd31, 0, 3'd7, 0, "R3");
    send(16'h4321, 8'd15, 0, 3'd7, 0, "R3");
    // R4..R7 rotates
    send(16'h8001, 8'd1, 0, 3'd0, 0, "R4");
    send(16'h8001, 8'd4, 0, 3'd1, 0, "R5");
    send(16'hA5A5, 8'd1, 0, 3'd1, 1, "R10");
    send(16'h8000, 8'd1, 0, 3'd2, 1, "R6");
    send(16'h1234, 8'd17, 0, 3'd2, 1, "R6");
    send(16'h0001, 8'd1, 0, 3'd3, 0, "R7");
    send(16'h0F0F, 8'd5, 0, 3'd3, 1, "R7");
    // R8 count masking
    send(16'hBEEF, 8'd0, 0, 3'd4, 1, "R8");
    send(16'hBEEF, 8'd32, 0, 3'd2, 1, "R8");
    send(16'hBEEF, 8'd33, 0, 3'd5, 0, "R8");
    send(16'h00FF, 8'd224, 1, 3'd0, 0, "R8");
    // R9 byte mode
    send(16'hA580, 8'd1, 1, 3'd4, 0, "R9");
    send(16'hA580, 8'd3, 1, 3'd7, 0, "R9");
    send(16'h5A01, 8'd9, 1, 3'd2, 1, "R9");
    send(16'h5A01, 8'd8, 1, 3'd5, 0, "R9");
    send(16'hC3C1, 8'd1, 1, 3'd3, 1, "R9");
    send(16'h7E81, 8'd10, 1, 3'd1, 0, "R9");

    // Random traffic, then with back-pressure (R11)
    for (int i = 0; i < 200; i++)
      send(16'($urandom), 8'($urandom % 40), 1'($urandom), 3'($urandom), 1'($urandom), "");
    bp_on = 1;
    for (int i = 0; i < 200; i++)
      send(16'($urandom), 8'($urandom % 40), 1'($urandom), 3'($urandom), 1'($urandom), "R11");

    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R11 drain: got %0d pending exp 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule